// File: doc/BRIEF.md
# Mirrored Butterfly Lane Permuter

This block reorders a vector of 2^n equal-width lanes through a fixed fabric of two-input multiplexers arranged as a forward butterfly followed by its mirror image. The first column of the mirror half would repeat the last forward column, so it is left out. That leaves 2n-1 columns of N multiplexers. Every multiplexer has a private select bit. With suitable selects the fabric can realise any lane permutation. Selecting one precomputed select word can therefore rotate or shuffle several independent frames that share the lanes, each frame by its own amount, in a single pass.

Select words are computed offline and supplied as a constant table parameter. At run time a caller presents a data vector, a table index and a valid strobe. The index and the data are captured together. The chosen select word then travels alongside the data through the columns. A per-column mask parameter inserts a register after any column, which trades latency for a shorter multiplexer chain.

Top module: `bbf_fabric`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid is low and out_data is all zeros.
- R2: Each accepted word (in_valid high at a clock edge) produces exactly one out_valid pulse, 1 + popcount(PIPE_MASK) cycles later, carrying that word's result.
- R3: Column s drives lane j from table bit s*LANES + j of the selected entry. A select of 0 takes lane j of the previous column. A select of 1 takes partner lane j XOR span. The span is LANES/2^(s+1) for s < n and 2^(s-n+1) for s >= n, giving the sequence LANES/2, ..., 1, 2, ..., LANES/2.
- R4: A table entry of all zeros delivers every input lane to the same output lane.
- R5: With LANES = 4 and table entry 12'hA35, the outputs are z3=x2, z2=x0, z1=x3 and z0=x1. In that entry, column 0 selects for lanes 3..0 are 0101, column 1 selects are 0011, and column 2 selects are 1010.
- R6: While in_valid is low, in_cfg and in_data are ignored and out_data holds the last result.
- R7: Words accepted on consecutive cycles with different table indices each come out permuted by their own entry, in order.
- R8: An index at or above NUM_CFG selects an all-zero select word, which gives the identity mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Captures in_cfg and in_data at this edge |
| in_cfg | input | CFG_W | Index of the select word in the table |
| in_data | input | LANES*LANE_W | Input lanes, lane j at bits j*LANE_W |
| out_valid | output | 1 | Result present on out_data this cycle |
| out_data | output | LANES*LANE_W | Permuted lanes, lane j at bits j*LANE_W |

## Verification
The case that needs care is a new word entering the capture register in the same cycle that an older word, carrying a different select word, is still moving through the registered columns or leaving them. If the select vector were not carried with its data, the old word would pick up the new word's selects. The bench provokes this by streaming every table index, in range and out of range, back to back with only occasional gaps. Each output is judged against an independently computed routing of its own entry and against its exact arrival cycle.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

  // Number of multiplexer columns for 2^log2n lanes.
  function automatic int bbf_stage_count(int log2n);
    return 2 * log2n - 1;
  endfunction

  // Distance between a lane and its partner in a given column.
  function automatic int bbf_span(int stage, int log2n);
    if (stage < log2n) return 1 << (log2n - 1 - stage);
    return 1 << (stage - log2n + 1);
  endfunction

  // Partner lane: spans are powers of two, so the partner differs in one bit.
  function automatic int bbf_partner(int lane, int span);
    return lane ^ span;
  endfunction

  // Cycles from capture to output: the capture register plus each masked column.
  function automatic int bbf_latency(logic [63:0] mask, int stages);
    int cnt;
    cnt = 1;
    for (int i = 0; i < stages; i++) cnt += int'(mask[i]);
    return cnt;
  endfunction

endpackage

// File: rtl/bbf_cfg_rom.sv
module bbf_cfg_rom #(
  parameter int NUM_CFG = 4,
  parameter int CFG_W   = 2,
  parameter int SEL_W   = 40,
  parameter logic [NUM_CFG*SEL_W-1:0] TABLE = '0
) (
  input  logic [CFG_W-1:0] idx,
  output logic [SEL_W-1:0] sel,
  output logic             hit
);

  assign hit = int'(idx) < NUM_CFG;

  always_comb begin
    sel = '0;
    if (hit) sel = TABLE[int'(idx)*SEL_W +: SEL_W];
  end

endmodule

// File: rtl/bbf_stage.sv
module bbf_stage
  import bbf_pkg::*;
#(
  parameter int LOG2_LANES = 3,
  parameter int LANE_W     = 8,
  parameter int STAGE_IDX  = 0,
  parameter bit REGISTERED = 1'b0,
  parameter int LANES      = 1 << LOG2_LANES,
  parameter int SEL_W      = bbf_stage_count(LOG2_LANES) * LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic                    valid_o,
  output logic [SEL_W-1:0]        sel_o,
  output logic [LANES*LANE_W-1:0] data_o
);

  localparam int SPAN = bbf_span(STAGE_IDX, LOG2_LANES);
  localparam int DW   = LANES * LANE_W;

  logic [LANES-1:0] lane_cross;  // lane takes its partner in this column
  logic [DW-1:0]    mux_data;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int PARTNER = bbf_partner(j, SPAN);
    assign lane_cross[j] = sel_i[STAGE_IDX*LANES + j];
    assign mux_data[j*LANE_W +: LANE_W] = lane_cross[j]
                                        ? data_i[PARTNER*LANE_W +: LANE_W]
                                        : data_i[j*LANE_W +: LANE_W];
  end

  if (REGISTERED) begin : g_reg
    logic             valid_q;
    logic [SEL_W-1:0] sel_q;
    logic [DW-1:0]    data_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        sel_q   <= '0;
        data_q  <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) begin
          sel_q  <= sel_i;
          data_q <= mux_data;
        end
      end
    end

    assign valid_o = valid_q;
    assign sel_o   = sel_q;
    assign data_o  = data_q;

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(data_o)); // R6
  end else begin : g_comb
    assign valid_o = valid_i;
    assign sel_o   = sel_i;
    assign data_o  = mux_data;
  end

endmodule

// File: rtl/bbf_fabric.sv
module bbf_fabric
  import bbf_pkg::*;
#(
  parameter int LOG2_LANES = 3,
  parameter int LANE_W     = 8,
  parameter int NUM_CFG    = 4,
  parameter int LANES      = 1 << LOG2_LANES,
  parameter int STAGES     = bbf_stage_count(LOG2_LANES),
  parameter int SEL_W      = STAGES * LANES,
  parameter int CFG_W      = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1,
  parameter logic [STAGES-1:0]        PIPE_MASK = '0,
  parameter logic [NUM_CFG*SEL_W-1:0] CFG_TABLE = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [CFG_W-1:0]        in_cfg,
  input  logic [LANES*LANE_W-1:0] in_data,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] out_data
);

  localparam int DW      = LANES * LANE_W;
  localparam int LATENCY = bbf_latency(64'(PIPE_MASK), STAGES);
  localparam int CNT_W   = $clog2(LATENCY + 2);

  // Capture register: index and data travel together.
  logic             cap_valid;
  logic [CFG_W-1:0] cap_cfg;
  logic [DW-1:0]    cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_cfg   <= '0;
      cap_data  <= '0;
    end else begin
      cap_valid <= in_valid;
      if (in_valid) begin
        cap_cfg  <= in_cfg;
        cap_data <= in_data;
      end
    end
  end

  logic [SEL_W-1:0] rom_sel;
  logic             rom_hit;

  bbf_cfg_rom #(
    .NUM_CFG (NUM_CFG),
    .CFG_W   (CFG_W),
    .SEL_W   (SEL_W),
    .TABLE   (CFG_TABLE)
  ) u_rom (
    .idx (cap_cfg),
    .sel (rom_sel),
    .hit (rom_hit)
  );

  logic [STAGES:0] col_valid;
  logic [SEL_W-1:0] col_sel  [STAGES+1];
  logic [DW-1:0]    col_data [STAGES+1];

  assign col_valid[0] = cap_valid;
  assign col_sel[0]   = rom_sel;
  assign col_data[0]  = cap_data;

  for (genvar s = 0; s < STAGES; s++) begin : g_col
    bbf_stage #(
      .LOG2_LANES (LOG2_LANES),
      .LANE_W     (LANE_W),
      .STAGE_IDX  (s),
      .REGISTERED (PIPE_MASK[s]),
      .LANES      (LANES),
      .SEL_W      (SEL_W)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (col_valid[s]),
      .sel_i   (col_sel[s]),
      .data_i  (col_data[s]),
      .valid_o (col_valid[s+1]),
      .sel_o   (col_sel[s+1]),
      .data_o  (col_data[s+1])
    );
  end

  assign out_valid = col_valid[STAGES];
  assign out_data  = col_data[STAGES];

  // Words accepted but not yet delivered, for the checks below.
  logic [CNT_W-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else if (in_valid && !out_valid) inflight <= inflight + 1'b1;
    else if (!in_valid && out_valid) inflight <= inflight - 1'b1;
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && out_data == '0)); // R1

  AST_NO_PHANTOM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != '0)); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R6

  AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !rom_hit) |-> (col_sel[0] == '0)); // R8

endmodule

// File: tb/bbf_fabric_tb.sv
`timescale 1ns/1ps
module bbf_fabric_tb;

  localparam int TB_LOG2  = 2;
  localparam int TB_LANES = 4;
  localparam int TB_W     = 8;
  localparam int TB_STG   = 3;
  localparam int TB_SELW  = TB_STG * TB_LANES;
  localparam int TB_CFGS  = 12;
  localparam int TB_CW    = 4;
  localparam int TB_DW    = TB_LANES * TB_W;
  localparam logic [TB_STG-1:0] TB_MASK = 3'b101;
  localparam int TB_LAT   = 3;

  function automatic logic [TB_CFGS*TB_SELW-1:0] tb_build();
    logic [TB_CFGS*TB_SELW-1:0] t;
    int unsigned seed;
    t = '0;
    seed = 32'h2468_ACE1;
    t[1*TB_SELW +: TB_SELW] = 12'hA35;
    for (int k = 2; k < TB_CFGS; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      t[k*TB_SELW +: TB_SELW] = TB_SELW'(seed >> 13);
    end
    return t;
  endfunction

  localparam logic [TB_CFGS*TB_SELW-1:0] TB_TABLE = tb_build();

  // Independent routing model: walk the columns lane by lane.
  function automatic logic [TB_DW-1:0] tb_route(logic [TB_DW-1:0] din, logic [TB_SELW-1:0] sv);
    logic [TB_W-1:0] cur [TB_LANES];
    logic [TB_W-1:0] nxt [TB_LANES];
    logic [TB_DW-1:0] r;
    for (int j = 0; j < TB_LANES; j++) cur[j] = din[j*TB_W +: TB_W];
    for (int s = 0; s < TB_STG; s++) begin
      int span;
      span = (s < TB_LOG2) ? (TB_LANES >> (s + 1)) : (2 << (s - TB_LOG2));
      for (int j = 0; j < TB_LANES; j++) begin
        int p;
        p = (((j / span) % 2) == 1) ? j - span : j + span;
        nxt[j] = sv[s*TB_LANES + j] ? cur[p] : cur[j];
      end
      for (int j = 0; j < TB_LANES; j++) cur[j] = nxt[j];
    end
    for (int j = 0; j < TB_LANES; j++) r[j*TB_W +: TB_W] = cur[j];
    return r;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid;
  logic [TB_CW-1:0] in_cfg;
  logic [TB_DW-1:0] in_data;
  logic out_valid;
  logic [TB_DW-1:0] out_data;

  always #2 clk = ~clk;

  bbf_fabric #(
    .LOG2_LANES (TB_LOG2),
    .LANE_W     (TB_W),
    .NUM_CFG    (TB_CFGS),
    .PIPE_MASK  (TB_MASK),
    .CFG_TABLE  (TB_TABLE)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_cfg    (in_cfg),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tx_idx = 0;
  int rx_idx = 0;
  bit done = 1'b0;
  int unsigned lcg = 32'h1357_9BDF;
  logic [TB_DW-1:0] exp_data [256];
  int               exp_cyc  [256];
  string            exp_tag  [256];
  logic [TB_DW-1:0] last_out = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [TB_DW-1:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return TB_DW'(lcg ^ (lcg >> 7));
  endfunction

  // Output monitor: result and arrival cycle of every delivered word.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (rx_idx >= tx_idx) begin
        errors++;
        $display("FAIL R2: unexpected out_valid, data %h, expected no word", out_data);
      end else begin
        if (out_data !== exp_data[rx_idx]) begin
          errors++;
          $display("FAIL %s: word %0d data %h, expected %h", exp_tag[rx_idx], rx_idx,
                   out_data, exp_data[rx_idx]);
        end
        checks++;
        if (cyc != exp_cyc[rx_idx] + TB_LAT) begin
          errors++;
          $display("FAIL R2: word %0d arrived cycle %0d, expected %0d", rx_idx, cyc,
                   exp_cyc[rx_idx] + TB_LAT);
        end
        rx_idx++;
      end
      last_out = out_data;
    end
  end

  task automatic send(input int cfg, input logic [TB_DW-1:0] d, input string pre);
    logic [TB_DW-1:0] e;
    string tag;
    @(negedge clk);
    in_valid = 1'b1;
    in_cfg   = TB_CW'(cfg);
    in_data  = d;
    if (cfg == 0) begin
      e = d; tag = "R4";
    end else if (cfg == 1) begin
      e[3*TB_W +: TB_W] = d[2*TB_W +: TB_W];
      e[2*TB_W +: TB_W] = d[0*TB_W +: TB_W];
      e[1*TB_W +: TB_W] = d[3*TB_W +: TB_W];
      e[0*TB_W +: TB_W] = d[1*TB_W +: TB_W];
      tag = "R5";
    end else if (cfg >= TB_CFGS) begin
      e = d; tag = "R8";
    end else begin
      e = tb_route(d, TB_TABLE[cfg*TB_SELW +: TB_SELW]); tag = "R3";
    end
    exp_data[tx_idx] = e;
    exp_cyc[tx_idx]  = cyc;
    exp_tag[tx_idx]  = {pre, tag};
    tx_idx++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_cfg   = TB_CW'(next_rand());
      in_data  = next_rand();
    end
  endtask

  initial begin
    in_valid = 1'b0;
    in_cfg   = '0;
    in_data  = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1: out_valid %b, expected 0", out_valid);
    end
    checks++;
    if (out_data !== '0) begin
      errors++; $display("FAIL R1: out_data %h, expected 0", out_data);
    end

    send(0, 32'h4433_2211, "");
    idle(2);
    send(1, 32'hD3C2_B1A0, "");
    idle(TB_LAT + 2);
    send(13, 32'h1020_3040, "");
    send(15, 32'h5566_7788, "");
    idle(TB_LAT + 2);

    // Back-to-back stream over every index, in range and out of range.
    for (int rep = 0; rep < 4; rep++) begin
      for (int c = 0; c < 16; c++) begin
        send(c, next_rand(), "R7 ");
        if (((rep + c) % 5) == 0) idle(1);
      end
    end
    idle(TB_LAT + 3);

    // Inputs ignored while in_valid is low; output holds.
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_data !== last_out) begin
        errors++;
        $display("FAIL R6: out_valid %b data %h, expected 0 and %h", out_valid, out_data, last_out);
      end
      in_valid = 1'b0;
      in_cfg   = TB_CW'(i % 2);
      in_data  = next_rand();
    end

    send(1, 32'h0F1E_2D3C, "");
    idle(TB_LAT + 3);
    checks++;
    if (rx_idx != tx_idx) begin
      errors++;
      $display("FAIL R2: delivered %0d words, expected %0d", rx_idx, tx_idx);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2: watchdog expired, delivered %0d, expected %0d", rx_idx, tx_idx);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule